// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This block resolves what happens when a return-from-trap instruction retires. It looks at the processor's privilege bit, its trap-enable bit and whether the core is in debug mode, together with a one-bit field taken from the instruction. From these it picks one of six outcomes. The outcome sets the address of the next instruction, says whether the trap-enable and privilege bits are rewritten and with which values, and says whether debug mode ends. It can also ask the surrounding pipeline to raise an illegal-instruction fault or to halt the core.

The checks run in a fixed order. An unprivileged return with traps disabled halts the core. An unprivileged return with traps enabled only falls through, because another unit already reports that fault. A privileged return with traps still enabled is illegal. A privileged return with traps disabled restores state. Outside debug mode the instruction field must be 0, and the saved return address and the previous-privilege bit are used. In debug mode the field must be 1, and the debug shadow copies are used. Any other combination just moves on to the following instruction.

All results are registered. They appear as one-cycle strobes on the clock edge that follows an instruction-valid cycle, so the register file and the fault logic can take them directly. The instruction size is a parameter (default 4 bytes). All address arithmetic wraps modulo 2^ADDR_W.

Top module: `trap_return_unit`

## Requirements
- R1: An active-low synchronous reset clears `res_vld`, `st_wr`, `dbg_clr`, `ill_req`, `halt_req`, `new_en`, `new_sup` and `next_pc`. Results already on the outputs are dropped in the same edge.
- R2: When `insn_vld` is low at a clock edge, every output is 0 after that edge.
- R3: If `sup_bit`=0 and `trap_en`=0, the result has `halt_req`=1, `next_pc`=`cur_pc`+INSN_BYTES and no status write.
- R4: If `sup_bit`=0 and `trap_en`=1, the result has `next_pc`=`cur_pc`+INSN_BYTES, and `st_wr`, `ill_req`, `halt_req` and `dbg_clr` are all 0.
- R5: If `sup_bit`=1 and `trap_en`=1, the result has `ill_req`=1, `next_pc`=`cur_pc`+INSN_BYTES and no status write.
- R6: If `sup_bit`=1, `trap_en`=0, `dbg_mode`=0 and `dbg_field`=0, the result has `next_pc`=`ret_pc`, `st_wr`=1, `new_en`=1, `new_sup`=`prev_sup` and `dbg_clr`=0.
- R7: If `sup_bit`=1, `trap_en`=0, `dbg_mode`=1 and `dbg_field`=1, the result has `next_pc`=`dbg_ret_pc`, `st_wr`=1, `new_en`=`dbg_ret_en`, `new_sup`=`dbg_ret_sup` and `dbg_clr`=1.
- R8: With `sup_bit`=1 and `trap_en`=0, if `dbg_field` does not match `dbg_mode`, the result only has `next_pc`=`cur_pc`+INSN_BYTES. In every result at most one of `halt_req`, `ill_req` and `st_wr` is 1.
- R9: A result appears exactly one clock edge after the edge at which `insn_vld` was 1, with `res_vld`=1, and lasts one cycle unless `insn_vld` stays high.
- R10: `cur_pc`+INSN_BYTES wraps modulo 2^ADDR_W (for example 0xFFFFFFFC advances to 0x00000000).
- R11: When `st_wr`=0, `new_en` and `new_sup` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | A return-from-trap instruction is retiring in this cycle |
| cur_pc | input | ADDR_W | Address of the instruction |
| sup_bit | input | 1 | Current privilege (supervisor) bit |
| prev_sup | input | 1 | Privilege bit saved at trap entry |
| trap_en | input | 1 | Current trap-enable bit |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_field | input | 1 | Instruction field: 0 selects a normal return, 1 a debug return |
| ret_pc | input | ADDR_W | Saved return address for a normal return |
| dbg_ret_pc | input | ADDR_W | Saved return address for a debug return |
| dbg_ret_en | input | 1 | Shadow trap-enable bit for a debug return |
| dbg_ret_sup | input | 1 | Shadow privilege bit for a debug return |
| res_vld | output | 1 | A result is present on the outputs |
| next_pc | output | ADDR_W | Address of the next instruction |
| st_wr | output | 1 | Write strobe for the trap-enable and privilege bits |
| new_en | output | 1 | New trap-enable value |
| new_sup | output | 1 | New privilege value |
| dbg_clr | output | 1 | Strobe that ends debug mode |
| ill_req | output | 1 | Illegal-instruction request |
| halt_req | output | 1 | Halt request |

## Verification
The debug return is the hardest outcome to reach. It needs four inputs to line up at once: privilege set, traps disabled, debug mode set and the instruction field set. Uniform random stimulus hits it about once in sixteen instructions, and it hits the two near misses (mode and field disagreeing) just as rarely. The bench therefore biases its random generator toward privileged returns with traps disabled, so these cases come up often. It also drives each of them directly, including a debug return whose shadow bits are all zero, so a design that falls back to the normal-return values would be caught.

// File: rtl/rft_pkg.sv
package rft_pkg;

   // Outcome of the ordered privilege / trap-enable / debug checks
   typedef enum logic [2:0] {
      RC_HALT = 3'd0,   // unprivileged, traps disabled
      RC_PRIV = 3'd1,   // unprivileged, traps enabled (fault reported elsewhere)
      RC_ILL  = 3'd2,   // privileged, traps enabled
      RC_NRET = 3'd3,   // normal restore
      RC_DRET = 3'd4,   // debug restore
      RC_NOP  = 3'd5    // mismatched mode / field
   } rft_case_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rft_decode.sv
module rft_decode
   import rft_pkg::*;
(
   input  logic      sup_bit,
   input  logic      trap_en,
   input  logic      dbg_mode,
   input  logic      dbg_field,
   output rft_case_e outcome
);

   always_comb begin
      if (!sup_bit && !trap_en)
         outcome = RC_HALT;
      else if (!sup_bit)
         outcome = RC_PRIV;
      else if (trap_en)
         outcome = RC_ILL;
      else if (!dbg_mode && !dbg_field)
         outcome = RC_NRET;
      else if (dbg_mode && dbg_field)
         outcome = RC_DRET;
      else
         outcome = RC_NOP;
   end

endmodule

// File: rtl/rft_pc_sel.sv
module rft_pc_sel
   import rft_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input  rft_case_e         outcome,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic [ADDR_W-1:0] dbg_ret_pc,
   output logic [ADDR_W-1:0] pc_out
);

   localparam int SHW = $clog2(INSN_BYTES);
   localparam int UPW = ADDR_W - SHW;

   logic [ADDR_W-1:0] seq_pc;

   generate
      if (SHW == 0) begin : g_full_add
         assign seq_pc = cur_pc + {{(ADDR_W-1){1'b0}}, 1'b1};
      end else begin : g_upper_add
         // step is a power of two: low bits pass through, only the upper part adds
         logic [UPW-1:0] upper;
         assign upper  = cur_pc[ADDR_W-1:SHW] + {{(UPW-1){1'b0}}, 1'b1};
         assign seq_pc = {upper, cur_pc[SHW-1:0]};
      end
   endgenerate

   always_comb begin
      unique case (outcome)
         RC_NRET: pc_out = ret_pc;
         RC_DRET: pc_out = dbg_ret_pc;
         default: pc_out = seq_pc;
      endcase
   end

endmodule

// File: rtl/rft_out_reg.sv
module rft_out_reg
   import rft_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_vld,
   input  rft_case_e         outcome,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic              prev_sup,
   input  logic              dbg_ret_en,
   input  logic              dbg_ret_sup,
   output logic              res_vld,
   output logic [ADDR_W-1:0] next_pc,
   output logic              st_wr,
   output logic              new_en,
   output logic              new_sup,
   output logic              dbg_clr,
   output logic              ill_req,
   output logic              halt_req
);

   logic d_wr, d_en, d_sup;

   always_comb begin
      d_wr  = 1'b0;
      d_en  = 1'b0;
      d_sup = 1'b0;
      if (outcome == RC_NRET) begin
         d_wr  = 1'b1;
         d_en  = 1'b1;
         d_sup = prev_sup;
      end else if (outcome == RC_DRET) begin
         d_wr  = 1'b1;
         d_en  = dbg_ret_en;
         d_sup = dbg_ret_sup;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !insn_vld) begin
         res_vld  <= 1'b0;
         next_pc  <= '0;
         st_wr    <= 1'b0;
         new_en   <= 1'b0;
         new_sup  <= 1'b0;
         dbg_clr  <= 1'b0;
         ill_req  <= 1'b0;
         halt_req <= 1'b0;
      end else begin
         res_vld  <= 1'b1;
         next_pc  <= pc_in;
         st_wr    <= d_wr;
         new_en   <= d_en;
         new_sup  <= d_sup;
         dbg_clr  <= (outcome == RC_DRET);
         ill_req  <= (outcome == RC_ILL);
         halt_req <= (outcome == RC_HALT);
      end
   end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import rft_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_vld,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic              sup_bit,
   input  logic              prev_sup,
   input  logic              trap_en,
   input  logic              dbg_mode,
   input  logic              dbg_field,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic [ADDR_W-1:0] dbg_ret_pc,
   input  logic              dbg_ret_en,
   input  logic              dbg_ret_sup,
   output logic              res_vld,
   output logic [ADDR_W-1:0] next_pc,
   output logic              st_wr,
   output logic              new_en,
   output logic              new_sup,
   output logic              dbg_clr,
   output logic              ill_req,
   output logic              halt_req
);

   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 64)
         else $error("trap_return_unit: ADDR_W out of range");
      assert (is_pow2(INSN_BYTES) && INSN_BYTES <= 16)
         else $error("trap_return_unit: INSN_BYTES must be a power of two up to 16");
   end

   rft_case_e         outcome;
   logic [ADDR_W-1:0] pc_sel;

   rft_decode u_dec (
      .sup_bit   (sup_bit),
      .trap_en   (trap_en),
      .dbg_mode  (dbg_mode),
      .dbg_field (dbg_field),
      .outcome   (outcome)
   );

   rft_pc_sel #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_pc (
      .outcome    (outcome),
      .cur_pc     (cur_pc),
      .ret_pc     (ret_pc),
      .dbg_ret_pc (dbg_ret_pc),
      .pc_out     (pc_sel)
   );

   rft_out_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .insn_vld    (insn_vld),
      .outcome     (outcome),
      .pc_in       (pc_sel),
      .prev_sup    (prev_sup),
      .dbg_ret_en  (dbg_ret_en),
      .dbg_ret_sup (dbg_ret_sup),
      .res_vld     (res_vld),
      .next_pc     (next_pc),
      .st_wr       (st_wr),
      .new_en      (new_en),
      .new_sup     (new_sup),
      .dbg_clr     (dbg_clr),
      .ill_req     (ill_req),
      .halt_req    (halt_req)
   );

endmodule

// File: rtl/rft_chk.sv
module rft_chk #(
   parameter int ADDR_W     = 32,
   parameter int INSN_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_vld,
   input logic [ADDR_W-1:0] cur_pc,
   input logic              sup_bit,
   input logic              prev_sup,
   input logic              trap_en,
   input logic              dbg_mode,
   input logic              dbg_field,
   input logic [ADDR_W-1:0] ret_pc,
   input logic [ADDR_W-1:0] dbg_ret_pc,
   input logic              dbg_ret_en,
   input logic              dbg_ret_sup,
   input logic              res_vld,
   input logic [ADDR_W-1:0] next_pc,
   input logic              st_wr,
   input logic              new_en,
   input logic              new_sup,
   input logic              dbg_clr,
   input logic              ill_req,
   input logic              halt_req
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !res_vld && !st_wr && !dbg_clr && !ill_req && !halt_req);

   assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(insn_vld) |-> !res_vld && !st_wr && !dbg_clr && !ill_req && !halt_req
                           && next_pc == '0);

   assert_halt_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(!sup_bit && !trap_en) && next_pc == $past(cur_pc) + STEP);

   assert_ill_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ill_req |-> $past(sup_bit && trap_en) && next_pc == $past(cur_pc) + STEP);

   assert_normal_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !dbg_clr) |-> new_en && new_sup == $past(prev_sup)
                              && next_pc == $past(ret_pc) && !$past(dbg_mode));

   assert_debug_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_clr |-> st_wr && $past(dbg_mode && dbg_field)
                  && next_pc == $past(dbg_ret_pc) && new_en == $past(dbg_ret_en));

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halt_req, ill_req, st_wr}));

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(insn_vld));

   assert_status_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !st_wr |-> !new_en && !new_sup);

endmodule

bind trap_return_unit rft_chk #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/sim_trap_return_unit.sv
module sim_trap_return_unit;

   localparam int AW = 32;
   localparam logic [AW-1:0] STEP = 32'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          insn_vld = 1'b0;
   logic [AW-1:0] cur_pc = '0, ret_pc = '0, dbg_ret_pc = '0;
   logic          sup_bit = 0, prev_sup = 0, trap_en = 0, dbg_mode = 0, dbg_field = 0;
   logic          dbg_ret_en = 0, dbg_ret_sup = 0;
   logic          res_vld, st_wr, new_en, new_sup, dbg_clr, ill_req, halt_req;
   logic [AW-1:0] next_pc;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   trap_return_unit #(.ADDR_W(AW), .INSN_BYTES(4)) u0 (.*);

   // packed result: {res_vld, next_pc, st_wr, new_en, new_sup, dbg_clr, ill_req, halt_req}
   function automatic logic [38:0] observed();
      return {res_vld, next_pc, st_wr, new_en, new_sup, dbg_clr, ill_req, halt_req};
   endfunction

   function automatic logic [38:0] expect_out(
      input logic [AW-1:0] pc, input logic s, input logic ps, input logic et,
      input logic dm, input logic df, input logic [AW-1:0] rp,
      input logic [AW-1:0] drp, input logic de, input logic ds);
      logic [AW-1:0] seq;
      seq = pc + STEP;
      if (!s && !et)      return {1'b1, seq, 6'b000001};
      else if (!s)        return {1'b1, seq, 6'b000000};
      else if (et)        return {1'b1, seq, 6'b000010};
      else if (!dm && !df) return {1'b1, rp, 1'b1, 1'b1, ps, 3'b000};
      else if (dm && df)  return {1'b1, drp, 1'b1, de, ds, 3'b100};
      else                return {1'b1, seq, 6'b000000};
   endfunction

   function automatic string tag_of(input logic s, input logic et, input logic dm, input logic df);
      if (!s && !et) return "R3";
      if (!s)        return "R4";
      if (et)        return "R5";
      if (!dm && !df) return "R6";
      if (dm && df)  return "R7";
      return "R8";
   endfunction

   task automatic check(input string tag, input logic [38:0] got, input logic [38:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic issue(input logic [AW-1:0] pc, input logic s, input logic ps,
                        input logic et, input logic dm, input logic df,
                        input logic [AW-1:0] rp, input logic [AW-1:0] drp,
                        input logic de, input logic ds, input string extra);
      @(negedge clk);
      insn_vld = 1; cur_pc = pc; sup_bit = s; prev_sup = ps; trap_en = et;
      dbg_mode = dm; dbg_field = df; ret_pc = rp; dbg_ret_pc = drp;
      dbg_ret_en = de; dbg_ret_sup = ds;
      @(negedge clk);
      check({tag_of(s, et, dm, df), extra},
            observed(), expect_out(pc, s, ps, et, dm, df, rp, drp, de, ds));
   endtask

   task automatic idle_check();
      @(negedge clk);
      insn_vld = 0; cur_pc = $urandom; sup_bit = 1; trap_en = 0; dbg_mode = 1;
      dbg_field = 1; ret_pc = $urandom; dbg_ret_pc = $urandom;
      @(negedge clk);
      check("R2 idle", observed(), 39'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset", observed(), 39'd0);
      rst_n = 1;

      // directed corner cases, one per outcome
      issue(32'h0000_1000, 0, 1, 0, 0, 0, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1, " halt");
      issue(32'h0000_2000, 0, 1, 1, 1, 1, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1, " priv");
      issue(32'h0000_3000, 1, 1, 1, 0, 0, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1, " illegal");
      issue(32'h0000_4000, 1, 0, 0, 0, 0, 32'h1234_5678, 32'hBBBB_0000, 1, 1, " normal ps0");
      issue(32'h0000_4000, 1, 1, 0, 0, 0, 32'h8765_4320, 32'hBBBB_0000, 0, 0, " normal ps1");
      issue(32'h0000_5000, 1, 1, 0, 1, 1, 32'hAAAA_0000, 32'hCAFE_0010, 0, 0, " debug zero shadow");
      issue(32'h0000_5000, 1, 0, 0, 1, 1, 32'hAAAA_0000, 32'hCAFE_0020, 1, 1, " debug shadow set");
      issue(32'h0000_6000, 1, 1, 0, 0, 1, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1, " field without mode");
      issue(32'h0000_7000, 1, 1, 0, 1, 0, 32'hAAAA_0000, 32'hBBBB_0000, 1, 1, " mode without field");
      issue(32'hFFFF_FFFC, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0, " R10 wrap");
      issue(32'hFFFF_FFFE, 1, 0, 0, 0, 1, 32'h0, 32'h0, 0, 0, " R10 wrap odd");
      idle_check();
      // R9: single-cycle strobe, then idle again
      idle_check();

      // R1: reset while a result is pending drops it
      @(negedge clk);
      insn_vld = 1; sup_bit = 0; trap_en = 0; rst_n = 0;
      @(negedge clk);
      check("R1 reset drops result", observed(), 39'd0);
      rst_n = 1; insn_vld = 0;
      @(negedge clk);
      check("R1 after reset", observed(), 39'd0);

      // constrained random, biased toward privileged returns with traps disabled
      for (int i = 0; i < 600; i++) begin
         logic s, et;
         s  = ($urandom % 4) != 0;
         et = ($urandom % 3) == 0;
         issue($urandom, s, 1'($urandom), et, 1'($urandom), 1'($urandom),
               $urandom, $urandom, 1'($urandom), 1'($urandom), " rnd R9 R11");
         if ($urandom % 8 == 0) idle_check();
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule